// File: doc/BRIEF.md
# Serial Time Slot Assigner

This block picks out a contiguous run of 8-bit time slots inside a time-division multiplexed serial frame, as used on ISDN or fractional-T1 style links. It follows a bit-clock enable and a frame sync pulse. After the sync it waits a programmable number of bit times (0 to 7), then counts bit times into slots. It raises a gate output for every bit time of the selected slots.

The selection is set by three configuration inputs: the first slot (0 to 127), the number of slots (1 to 15, where 0 disables the gate) and the bit delay after sync. The bit delay makes up for the latency of whatever logic detects the frame sync upstream. One instance serves one direction of traffic. The gate is meant to qualify a data shifter, which sits outside this block, as does frame detection.

Top module: `tsa_gate`

## Requirements
- R1: After reset, and until the first frame sync is taken, `gate_o` is 0 and `slot_idx_o` is 0.
- R2: `fsync_i` is acted on only in a cycle where `bit_en_i` is 1. The bit time that carries an accepted sync is bit time 0 of the frame. A sync with `bit_en_i` at 0 has no effect.
- R3: The bit delay `cfg_ofs_i` is captured when a sync is accepted. Slot 0 starts at bit time `cfg_ofs_i` of the frame. While the delay runs, the gate is 0 and `slot_idx_o` reads 0.
- R4: Each slot lasts 8 bit times. `slot_idx_o` holds the index of the slot that the current bit time belongs to, counting up from 0.
- R5: `gate_o` is 1 for exactly the bit times of slots `cfg_first_i` through `cfg_first_i + cfg_cnt_i - 1`. `cfg_first_i` ranges over 0..127 and `cfg_cnt_i` over 1..15.
- R6: When `cfg_cnt_i` is 0, `gate_o` stays 0.
- R7: An accepted sync restarts the delay and slot counting at any point, including in the middle of a frame or during the delay.
- R8: `slot_idx_o` saturates at 255 and never wraps back to a lower slot within a frame.
- R9: Both outputs are registered. Each output reflects the bit time taken at a clock edge from the cycle after that edge. Both outputs hold their values through cycles where `bit_en_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_en_i | input | 1 | One bit time per cycle in which this is high |
| fsync_i | input | 1 | Frame sync, valid with bit_en_i |
| cfg_first_i | input | 7 | First selected slot |
| cfg_cnt_i | input | 4 | Number of selected slots, 0 disables |
| cfg_ofs_i | input | 3 | Bit delay from sync to slot 0 |
| gate_o | output | 1 | High during selected slots |
| slot_idx_o | output | 8 | Current slot index, 0 while not counting |

## Verification
Every result of this block appears one clock edge after the bit time that causes it. A sync, a delay expiry or a slot boundary taken at edge N therefore shows on `gate_o` and `slot_idx_o` from the cycle after edge N. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares both outputs at the next falling edge, after every single cycle, including cycles with no bit enable, where the outputs must not move.

// File: rtl/tsa_pkg.sv
package tsa_pkg;

  // Phase of the frame position tracker
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,  // no sync seen since reset
    PH_DELAY = 2'd1,  // counting the post-sync bit delay
    PH_RUN   = 2'd2   // counting bits into slots
  } tsa_phase_e;

endpackage

// File: rtl/tsa_bit_timer.sv
module tsa_bit_timer
  import tsa_pkg::*;
#(
  parameter int OFS_W         = 3,
  parameter int BITS_PER_SLOT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_en_i,
  input  logic             fsync_i,
  input  logic [OFS_W-1:0] ofs_i,
  output tsa_phase_e       ph_q_o,
  output tsa_phase_e       ph_nxt_o,
  output logic             slot_clr_o,
  output logic             slot_inc_o
);

  localparam int BIT_W = (BITS_PER_SLOT > 1) ? $clog2(BITS_PER_SLOT) : 1;
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(BITS_PER_SLOT - 1);

  tsa_phase_e       ph_q, ph_nxt;
  logic [OFS_W-1:0] dly_q, dly_nxt;
  logic [BIT_W-1:0] bit_q, bit_nxt;
  logic             clr, inc;

  always_comb begin
    ph_nxt  = ph_q;
    dly_nxt = dly_q;
    bit_nxt = bit_q;
    clr     = 1'b0;
    inc     = 1'b0;
    if (bit_en_i) begin
      if (fsync_i) begin
        bit_nxt = '0;
        if (ofs_i == '0) begin
          ph_nxt  = PH_RUN;
          dly_nxt = '0;
          clr     = 1'b1;
        end else begin
          ph_nxt  = PH_DELAY;
          dly_nxt = ofs_i;
        end
      end else begin
        unique case (ph_q)
          PH_DELAY: begin
            if (dly_q == OFS_W'(1)) begin
              ph_nxt  = PH_RUN;
              dly_nxt = '0;
              bit_nxt = '0;
              clr     = 1'b1;
            end else begin
              dly_nxt = dly_q - OFS_W'(1);
            end
          end
          PH_RUN: begin
            if (bit_q == BIT_LAST) begin
              bit_nxt = '0;
              inc     = 1'b1;
            end else begin
              bit_nxt = bit_q + BIT_W'(1);
            end
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q  <= PH_IDLE;
      dly_q <= '0;
      bit_q <= '0;
    end else if (bit_en_i) begin
      ph_q  <= ph_nxt;
      dly_q <= dly_nxt;
      bit_q <= bit_nxt;
    end
  end

  assign ph_q_o     = ph_q;
  assign ph_nxt_o   = ph_nxt;
  assign slot_clr_o = clr;
  assign slot_inc_o = inc;

  // R3
  sync_zero_ofs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en_i && fsync_i && ofs_i == '0) |=> (ph_q == PH_RUN && bit_q == '0));

  // R3
  sync_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en_i && fsync_i && ofs_i != '0) |=> (ph_q == PH_DELAY && dly_q == $past(ofs_i)));

  // R9
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en_i |=> ($stable(ph_q) && $stable(bit_q) && $stable(dly_q)));

endmodule

// File: rtl/tsa_slot_counter.sv
module tsa_slot_counter #(
  parameter int SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_en_i,
  input  logic              clr_i,
  input  logic              inc_i,
  output logic [SLOT_W-1:0] slot_q_o,
  output logic [SLOT_W-1:0] slot_nxt_o
);

  localparam logic [SLOT_W-1:0] SLOT_MAX = '1;

  logic [SLOT_W-1:0] slot_q, slot_nxt;

  always_comb begin
    slot_nxt = slot_q;
    if (clr_i)
      slot_nxt = '0;
    else if (inc_i && slot_q != SLOT_MAX)
      slot_nxt = slot_q + SLOT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      slot_q <= '0;
    else if (bit_en_i)
      slot_q <= slot_nxt;
  end

  assign slot_q_o   = slot_q;
  assign slot_nxt_o = slot_nxt;

  // R8
  slot_no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en_i && !clr_i) |=> (slot_q >= $past(slot_q)));

endmodule

// File: rtl/tsa_window.sv
module tsa_window
  import tsa_pkg::*;
#(
  parameter int SLOT_W  = 8,
  parameter int FIRST_W = 7,
  parameter int CNT_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en_i,
  input  tsa_phase_e         ph_nxt_i,
  input  logic [SLOT_W-1:0]  slot_nxt_i,
  input  logic [FIRST_W-1:0] first_i,
  input  logic [CNT_W-1:0]   cnt_i,
  output logic               gate_o
);

  localparam int BASE_W = (SLOT_W > FIRST_W) ? SLOT_W : FIRST_W;
  localparam int SUM_W  = ((BASE_W > CNT_W) ? BASE_W : CNT_W) + 1;

  logic [SUM_W-1:0] lo, hi, pos;
  logic             hit, gate_q;

  always_comb begin
    lo  = SUM_W'(first_i);
    hi  = SUM_W'(first_i) + SUM_W'(cnt_i);
    pos = SUM_W'(slot_nxt_i);
    hit = (ph_nxt_i == PH_RUN) && (cnt_i != '0) && (pos >= lo) && (pos < hi);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      gate_q <= 1'b0;
    else if (bit_en_i)
      gate_q <= hit;
  end

  assign gate_o = gate_q;

  // R6
  zero_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en_i && cnt_i == '0) |=> !gate_q);

endmodule

// File: rtl/tsa_gate.sv
module tsa_gate
  import tsa_pkg::*;
#(
  parameter int FIRST_W       = 7,
  parameter int CNT_W         = 4,
  parameter int OFS_W         = 3,
  parameter int SLOT_W        = 8,
  parameter int BITS_PER_SLOT = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bit_en_i,
  input  logic               fsync_i,
  input  logic [FIRST_W-1:0] cfg_first_i,
  input  logic [CNT_W-1:0]   cfg_cnt_i,
  input  logic [OFS_W-1:0]   cfg_ofs_i,
  output logic               gate_o,
  output logic [SLOT_W-1:0]  slot_idx_o
);

  tsa_phase_e        ph_q, ph_nxt;
  logic              slot_clr, slot_inc;
  logic [SLOT_W-1:0] slot_q, slot_nxt;

  tsa_bit_timer #(
    .OFS_W        (OFS_W),
    .BITS_PER_SLOT(BITS_PER_SLOT)
  ) u_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en_i  (bit_en_i),
    .fsync_i   (fsync_i),
    .ofs_i     (cfg_ofs_i),
    .ph_q_o    (ph_q),
    .ph_nxt_o  (ph_nxt),
    .slot_clr_o(slot_clr),
    .slot_inc_o(slot_inc)
  );

  tsa_slot_counter #(
    .SLOT_W(SLOT_W)
  ) u_slots (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en_i  (bit_en_i),
    .clr_i     (slot_clr),
    .inc_i     (slot_inc),
    .slot_q_o  (slot_q),
    .slot_nxt_o(slot_nxt)
  );

  tsa_window #(
    .SLOT_W (SLOT_W),
    .FIRST_W(FIRST_W),
    .CNT_W  (CNT_W)
  ) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en_i  (bit_en_i),
    .ph_nxt_i  (ph_nxt),
    .slot_nxt_i(slot_nxt),
    .first_i   (cfg_first_i),
    .cnt_i     (cfg_cnt_i),
    .gate_o    (gate_o)
  );

  assign slot_idx_o = (ph_q == PH_RUN) ? slot_q : '0;

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ph_q != PH_RUN) |-> (!gate_o && slot_idx_o == '0));

  // R5
  gate_low_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(bit_en_i) && gate_o) |-> (slot_idx_o >= SLOT_W'($past(cfg_first_i))));

  // R7
  restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_en_i && fsync_i && cfg_ofs_i == '0) |=> (slot_idx_o == '0));

endmodule

// File: tb/tsa_gate_test.sv
module tsa_gate_test;

  logic       clk;
  logic       rst_n;
  logic       bit_en_i;
  logic       fsync_i;
  logic [6:0] cfg_first_i;
  logic [3:0] cfg_cnt_i;
  logic [2:0] cfg_ofs_i;
  logic       gate_o;
  logic [7:0] slot_idx_o;

  int    checks;
  int    failures;
  string cur_tag;

  // reference model state
  bit m_seen;
  int m_t;
  int m_ofs;

  tsa_gate uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_en_i   (bit_en_i),
    .fsync_i    (fsync_i),
    .cfg_first_i(cfg_first_i),
    .cfg_cnt_i  (cfg_cnt_i),
    .cfg_ofs_i  (cfg_ofs_i),
    .gate_o     (gate_o),
    .slot_idx_o (slot_idx_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  function automatic int exp_slot();
    int p;
    if (!m_seen) return -1;
    p = m_t - m_ofs;
    if (p < 0) return -1;
    if (p / 8 > 255) return 255;
    return p / 8;
  endfunction

  function automatic bit exp_gate();
    int s;
    s = exp_slot();
    if (s < 0 || cfg_cnt_i == 0) return 1'b0;
    return (s >= int'(cfg_first_i)) && (s < int'(cfg_first_i) + int'(cfg_cnt_i));
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick(input bit en, input bit fs);
    int s;
    bit g;
    bit_en_i = en;
    fsync_i  = fs;
    @(posedge clk);
    // reference update for the edge (config is stable around it)
    if (en) begin
      if (fs) begin
        m_seen = 1'b1;
        m_t    = 0;
        m_ofs  = int'(cfg_ofs_i);
        g      = exp_gate();
      end else begin
        if (m_seen && m_t < 1000000) m_t++;
        g = exp_gate();
      end
    end else begin
      g = gate_o;
    end
    @(negedge clk);
    s = exp_slot();
    if (en) begin
      check({cur_tag, " gate"}, int'(gate_o), int'(g));
      check({cur_tag, " slot"}, int'(slot_idx_o), (s < 0) ? 0 : s);
    end else begin
      // R9: no bit time, nothing moves
      check({cur_tag, " hold gate"}, int'(gate_o), int'(g));
      check({cur_tag, " hold slot"}, int'(slot_idx_o), (s < 0) ? 0 : s);
    end
  endtask

  task automatic set_cfg(input int first, input int cnt, input int ofs);
    cfg_first_i = 7'(first);
    cfg_cnt_i   = 4'(cnt);
    cfg_ofs_i   = 3'(ofs);
  endtask

  task automatic frame(input int first, input int cnt, input int ofs,
                       input int nbits, input int en_pct);
    set_cfg(first, cnt, ofs);
    tick(1'b1, 1'b1);
    for (int i = 0; i < nbits; i++) begin
      if (en_pct < 100)
        while ($urandom_range(99) >= en_pct) tick(1'b0, 1'b0);
      tick(1'b1, 1'b0);
    end
  endtask

  initial begin
    int cyc;
    cyc = 0;
    while (cyc < 200000) begin
      @(posedge clk);
      cyc++;
    end
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd2718));
    checks   = 0;
    failures = 0;
    m_seen   = 1'b0;
    m_t      = 0;
    m_ofs    = 0;
    bit_en_i = 1'b0;
    fsync_i  = 1'b0;
    set_cfg(3, 2, 0);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 reset gate", int'(gate_o), 0);
    check("R1 reset slot", int'(slot_idx_o), 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: bit times with no sync yet stay quiet
    cur_tag = "R1";
    for (int i = 0; i < 40; i++) tick(1'b1, 1'b0);

    // R2: sync without bit enable is ignored
    cur_tag = "R2";
    for (int i = 0; i < 5; i++) tick(1'b0, 1'b1);
    for (int i = 0; i < 10; i++) tick(1'b1, 1'b0);

    // R5: zero delay, first slot 0, single slot
    cur_tag = "R5";
    frame(0, 1, 0, 30, 100);
    // R3: maximum delay, late window
    cur_tag = "R3";
    frame(2, 3, 7, 60, 100);
    // R5: upper corner of first slot and count
    cur_tag = "R5";
    frame(127, 15, 7, 1150, 100);
    // R6: zero count
    cur_tag = "R6";
    frame(0, 0, 0, 200, 100);
    // R4: slot steps with gapped bit enable
    cur_tag = "R4";
    frame(1, 2, 3, 60, 50);
    // R7: restart mid-frame and during the delay
    cur_tag = "R7";
    frame(1, 4, 0, 21, 100);
    frame(0, 3, 5, 3, 100);
    frame(0, 3, 2, 40, 100);
    // R8: run far past slot 255
    cur_tag = "R8";
    frame(250, 15, 1, 2100, 100);
    // R9: sparse bit enable
    cur_tag = "R9";
    frame(4, 5, 6, 80, 30);

    // random frames
    cur_tag = "R5";
    for (int k = 0; k < 25; k++) begin
      frame(int'($urandom_range(127)), int'($urandom_range(15)),
            int'($urandom_range(7)), int'($urandom_range(1300, 20)),
            int'($urandom_range(100, 40)));
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule